// File: doc/BRIEF.md
# Display Memory Fetch Bus Master

This block is the real-time master that pulls display words out of an external memory over a shared 16-bit bus, on which address and data take turns. The display engine hands it a burst request: a start byte address, a word count and a warning length. The block then raises a bus request so that the host can finish whatever cycle it is in. It waits the programmed number of memory cycles and then runs one read cycle per word. Each fetched word comes back to the engine with a one-clock valid flag.

Every memory cycle lasts three base clocks. In the first clock the address is on the bus with the address strobe inactive, so external latches see a settled value. In the second clock the address strobe falls while the address is still held. In the third clock the block stops driving the bus and pulls both data strobes low together, and the memory drives the word. The word is sampled on the clock edge that ends that third clock. The read/write line always reads. Word addresses are even, and the even byte sits on the upper half of the bus. When the last word is captured, the block pulses `done` and drops the bus request on the same edge. It accepts a new burst only after the request has been low for at least one clock.

Top module: `dmf_bus_master`

## Requirements
- R1: During and after reset, `bus_req`, `ad_oe`, `word_valid` and `done` are 0, `as_n`, `uds_n` and `lds_n` are 1 (inactive), and `req_ready` is 1.
- R2: A burst is accepted on a clock edge where `req_valid` and `req_ready` are both 1 and `req_words` is nonzero. A request with `req_words` = 0 is ignored: `bus_req` stays 0 and `req_ready` stays 1.
- R3: `bus_req` rises on the edge that accepts a burst. The first falling edge of `as_n` comes exactly 3*W+1 clocks after that rise, where W is `req_warn` limited to WARN_MAX (46). Larger values act as 46.
- R4: Each memory cycle lasts 3 clocks. Clock 1: `ad_oe`=1, the address is on `ad_out`, `as_n`=1. Clock 2: `as_n`=0 and the address is still driven and unchanged. Clock 3: `as_n`=0, `ad_oe`=0, and `uds_n` and `lds_n` are both 0. `rd_nwr` is 1 at all times. Consecutive words of a burst are 3 clocks apart.
- R5: The value on `ad_in` at the edge that ends clock 3 appears on `word_data`, with `word_valid`=1 for exactly one clock. A burst delivers exactly `req_words` words.
- R6: The first address is `req_addr` with bit 0 forced to 0. Each following word is 2 higher, and the address wraps modulo 2^BUS_W. Bit 0 of `ad_out` is always 0 while driven.
- R7: `done` is 1 for one clock, in the same clock as the last `word_valid`, and `bus_req` is already 0 in that clock.
- R8: `req_ready` is 0 from acceptance until one clock after `done`. After a burst ends, `bus_req` stays 0 for at least one clock before the next burst raises it.
- R9: `bus_req` stays 1 without a break from its rise until the last word is captured, and `as_n` is never 0 while `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_addr | input | BUS_W | Start byte address (bit 0 ignored) |
| req_words | input | CNT_W | Number of words to fetch |
| req_warn | input | WARN_W | Warning length in memory cycles |
| req_ready | output | 1 | Idle and able to take a burst |
| bus_req | output | 1 | Bus request to the host |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| rd_nwr | output | 1 | Read/write line, 1 = read |
| ad_oe | output | 1 | Block drives the shared bus |
| ad_out | output | BUS_W | Address driven onto the bus |
| ad_in | input | BUS_W | Data returned on the bus |
| word_valid | output | 1 | Fetched word valid |
| word_data | output | BUS_W | Fetched word |
| done | output | 1 | Last word of the burst delivered |

## Verification
Two events meet on one clock edge: the capture of the final word and the end of the burst. On that edge `word_valid`, `done` and the release of `bus_req` all happen, and a new request already waiting must not be taken there. The bench provokes this by presenting a second burst with `req_valid` held high while the first is still running. It then checks three things: `done` coincides with the last word and with `bus_req` low, `req_ready` is still 0 in that clock, and the second burst raises `bus_req` again only after at least one low clock, with its own addresses and data.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_WARN, ST_CYC, ST_REL} dmf_state_e;
    typedef enum logic [1:0] {PH_ADDR, PH_LATCH, PH_DATA} dmf_phase_e;
endpackage

// File: rtl/dmf_warn_timer.sv
module dmf_warn_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             at_last
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == TMR_W'(1));
endmodule

// File: rtl/dmf_word_addr.sv
module dmf_word_addr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load) begin
            ag_d.addr = {base[ADDR_W-1:1], 1'b0};
            ag_d.rem  = count;
        end else if (step) begin
            ag_d.addr = ag_q.addr + ADDR_W'(2);
            ag_d.rem  = ag_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr = ag_q.addr;
    assign last = (ag_q.rem == CNT_W'(1));
endmodule

// File: rtl/dmf_bus_master.sv
module dmf_bus_master
    import dmf_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int CNT_W    = 8,
    parameter int WARN_W   = 6,
    parameter int WARN_MAX = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [CNT_W-1:0] req_words,
    input  logic [WARN_W-1:0] req_warn,
    output logic             req_ready,
    output logic             bus_req,
    output logic             as_n,
    output logic             uds_n,
    output logic             lds_n,
    output logic             rd_nwr,
    output logic             ad_oe,
    output logic [BUS_W-1:0] ad_out,
    input  logic [BUS_W-1:0] ad_in,
    output logic             word_valid,
    output logic [BUS_W-1:0] word_data,
    output logic             done
);
    localparam int TMR_W = $clog2(3 * WARN_MAX + 1);

    typedef struct packed {
        dmf_state_e       st;
        dmf_phase_e       ph;
        logic [BUS_W-1:0] word;
        logic             wvalid;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WARN_W-1:0] warn_eff;
    logic [TMR_W-1:0]  warn_clks;
    logic              accept;
    logic              tmr_load, tmr_last;
    logic              ag_load, ag_step, ag_last;
    logic [BUS_W-1:0]  ag_addr;

    assign warn_eff  = (req_warn > WARN_W'(WARN_MAX)) ? WARN_W'(WARN_MAX) : req_warn;
    assign warn_clks = TMR_W'(warn_eff) * TMR_W'(3);
    assign accept    = req_valid && (ctl_q.st == ST_IDLE) && (req_words != '0);

    dmf_warn_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (warn_clks),
        .at_last  (tmr_last)
    );

    dmf_word_addr #(.ADDR_W(BUS_W), .CNT_W(CNT_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ag_load),
        .base  (req_addr),
        .count (req_words),
        .step  (ag_step),
        .addr  (ag_addr),
        .last  (ag_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.wvalid = 1'b0;
        ctl_d.done   = 1'b0;
        tmr_load     = 1'b0;
        ag_load      = 1'b0;
        ag_step      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    ag_load  = 1'b1;
                    ctl_d.ph = PH_ADDR;
                    ctl_d.st = (warn_eff == '0) ? ST_CYC : ST_WARN;
                end
            end
            ST_WARN: begin
                if (tmr_last) begin
                    ctl_d.st = ST_CYC;
                    ctl_d.ph = PH_ADDR;
                end
            end
            ST_CYC: begin
                unique case (ctl_q.ph)
                    PH_ADDR:  ctl_d.ph = PH_LATCH;
                    PH_LATCH: ctl_d.ph = PH_DATA;
                    default: begin
                        ctl_d.word   = ad_in;
                        ctl_d.wvalid = 1'b1;
                        ag_step      = 1'b1;
                        ctl_d.ph     = PH_ADDR;
                        if (ag_last) begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_REL;
                        end
                    end
                endcase
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
            ctl_q.ph <= PH_ADDR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic in_cyc;
    assign in_cyc     = (ctl_q.st == ST_CYC);
    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign bus_req    = (ctl_q.st == ST_WARN) || in_cyc;
    assign ad_oe      = in_cyc && (ctl_q.ph != PH_DATA);
    assign ad_out     = ag_addr;
    assign as_n       = !(in_cyc && (ctl_q.ph != PH_ADDR));
    assign uds_n      = !(in_cyc && (ctl_q.ph == PH_DATA));
    assign lds_n      = !(in_cyc && (ctl_q.ph == PH_DATA));
    assign rd_nwr     = 1'b1;
    assign word_valid = ctl_q.wvalid;
    assign word_data  = ctl_q.word;
    assign done       = ctl_q.done;
endmodule

// File: rtl/dmf_bus_master_chk.sv
module dmf_bus_master_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             bus_req,
    input logic             as_n,
    input logic             uds_n,
    input logic             ad_oe,
    input logic [BUS_W-1:0] ad_out,
    input logic             word_valid,
    input logic             done
);
    p_ds_inside_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uds_n |-> !as_n);
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uds_n |-> !ad_oe);
    p_as_leads_ds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uds_n) |-> $past(!as_n));
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && ad_oe) |-> $stable(ad_out));
    p_addr_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !ad_out[0]);
    p_done_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_valid && !bus_req));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_ready_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req);
    p_strobe_under_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> bus_req);
endmodule

bind dmf_bus_master dmf_bus_master_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_dmf_bus_master.sv
module tb_dmf_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    // each entry: {start address[29:14], word count[13:6], warning[5:0]}
    localparam logic [29:0] VEC [NVEC] = '{
        {16'h1000, 8'd4, 6'd0},
        {16'h2001, 8'd3, 6'd2},
        {16'hFFFC, 8'd3, 6'd1},
        {16'h0400, 8'd1, 6'd46},
        {16'h0100, 8'd2, 6'd60}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_words = '0;
    logic [5:0]  req_warn = '0;
    logic        req_ready, bus_req, as_n, uds_n, lds_n, rd_nwr, ad_oe;
    logic [15:0] ad_out, ad_in, word_data;
    logic        word_valid, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmf_bus_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_words(req_words), .req_warn(req_warn), .req_ready(req_ready),
        .bus_req(bus_req), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rd_nwr(rd_nwr), .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in),
        .word_valid(word_valid), .word_data(word_data), .done(done)
    );

    function automatic logic [15:0] pat(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // memory model: latch address on the strobe fall, return data under the data strobes
    logic [15:0] lat = '0;
    always @(negedge as_n) lat = ad_out;
    assign ad_in = !uds_n ? pat(lat) : 16'h0000;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R5 act=hung exp=finished");
        summary();
    end

    // monitor
    logic [15:0] exp_addr = '0, next_base = '0;
    int  words = 0, dones = 0, req_rise = 0, as_fall = 0, last_wv = 0, low_run = 0;
    bit  mon_on = 0, in_burst = 0, as_seen = 0, have_last = 0, saw_done = 0;

    always @(negedge clk) if (mon_on) begin
        if (bus_req && !in_burst) begin
            if (saw_done) chk(low_run >= 1, "R8 gap", low_run, 1);
            in_burst = 1; req_rise = cyc; as_seen = 0; low_run = 0;
        end
        if (!bus_req) low_run++;
        if (in_burst && !as_n && !as_seen) begin as_seen = 1; as_fall = cyc; end
        if (!uds_n) chk(!lds_n && rd_nwr && !ad_oe && !as_n, "R4 data phase",
                        {lds_n, rd_nwr, ad_oe, as_n}, 4'b0100);
        if (!as_n && ad_oe) chk(ad_out == exp_addr, "R6 address", ad_out, exp_addr);
        if (word_valid) begin
            chk(word_data == pat(exp_addr), "R5 data", word_data, pat(exp_addr));
            if (have_last) chk(cyc - last_wv == 3, "R4 spacing", cyc - last_wv, 3);
            last_wv = cyc; have_last = 1; exp_addr += 16'd2; words++;
        end
        if (in_burst && !bus_req && !done) chk(0, "R9 request dropped", 0, 1);
        if (done) begin
            chk(!bus_req && word_valid, "R7 done", {bus_req, word_valid}, 2'b01);
            chk(!req_ready, "R8 ready in release", req_ready, 0);
            dones++; in_burst = 0; have_last = 0; saw_done = 1; low_run = 0;
            exp_addr = next_base;
        end
    end

    task automatic issue(input logic [15:0] a, input logic [7:0] c, input logic [5:0] w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_words = c; req_warn = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_burst(input logic [15:0] a, input logic [7:0] c, input logic [5:0] w);
        int wexp;
        words = 0; dones = 0;
        exp_addr = {a[15:1], 1'b0}; next_base = exp_addr;
        issue(a, c, w);
        for (int i = 0; i < 2000 && dones == 0; i++) @(negedge clk);
        wexp = (w > 46) ? 46 : int'(w);
        chk(dones == 1, "R7 done count", dones, 1);
        chk(words == int'(c), "R5 word count", words, c);
        chk(as_fall - req_rise == 3 * wexp + 1, "R3 warning", as_fall - req_rise, 3 * wexp + 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!bus_req && !ad_oe && !word_valid && !done, "R1 idle outputs",
            {bus_req, ad_oe, word_valid, done}, 0);
        chk(as_n && uds_n && lds_n && req_ready, "R1 strobes/ready",
            {as_n, uds_n, lds_n, req_ready}, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req && rd_nwr, "R1 after release", {req_ready, bus_req, rd_nwr}, 3'b101);
        mon_on = 1;

        // R3 R5 R6: table of bursts (odd start, wrap, max and clamped warning)
        for (int v = 0; v < NVEC; v++)
            run_burst(VEC[v][29:14], VEC[v][13:6], VEC[v][5:0]);

        // R2: zero-length request ignored
        @(negedge clk);
        req_addr = 16'h0800; req_words = 8'd0; req_warn = 6'd0; req_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!bus_req && req_ready, "R2 zero count", {bus_req, req_ready}, 2'b01);
        end
        req_valid = 1'b0;

        // R8: second request waiting while the first burst ends
        words = 0; dones = 0;
        exp_addr = 16'h3000; next_base = 16'h5000;
        @(negedge clk);
        req_addr = 16'h3000; req_words = 8'd2; req_warn = 6'd0; req_valid = 1'b1;
        @(negedge clk);
        while (!bus_req) @(negedge clk);
        req_addr = 16'h5000; req_words = 8'd2; req_warn = 6'd1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000 && dones < 2; i++) @(negedge clk);
        chk(dones == 2, "R8 back-to-back bursts", dones, 2);
        chk(words == 4, "R8 back-to-back words", words, 4);
        repeat (3) @(negedge clk);
        chk(!bus_req && req_ready, "R8 final idle", {bus_req, req_ready}, 2'b01);
        summary();
    end
endmodule